// File: doc/BRIEF.md
# Commutation Waveform Sequencer

This block routes one PWM waveform onto six motor-phase drive pins. A six-bit pattern selects which pins carry the PWM signal; the other pins stay low. Software fills a bank of twelve pattern slots through a simple write port. Hardware then loads the slots into a pending pattern one after another. A load can come from a software write of slot 0, from the underflow of a built-in 16-bit delay timer, or from a change on three rotor-position inputs. A three-bit transfer mode chooses which of these sources can start a load.

A loaded pattern reaches the pins only at the next falling edge of the PWM input. A pin therefore never starts or ends partway through a PWM pulse. An emergency-off input drives all pins low through purely combinational logic. The block also latches that condition, so the pins stay off until software clears the latch after the input has returned low.

The write port, the rotor inputs and the kill controls are plain control pins with no handshake. A write takes effect in the cycle in which `wr_en` is high. Nothing can stall the block, so there is no back-pressure.

Top module: `commutation_seq`

## Requirements
- R1: After reset, every pin is low, the slot index is 0, the pending and active patterns are 0, and the mode is 0, in which no load source is enabled.
- R2: When no kill is in force, `pat_out[i]` equals `pwm_in` AND bit i of the active pattern. While `pwm_in` is low, all pins are low.
- R3: A newly loaded pattern becomes the active pattern only at the first clock edge that sees `pwm_in` low after it was high. A load made while `pwm_in` is high does not change the pins during that high phase.
- R4: In mode 1, a write to address 0 loads the written data, bits 5:0, straight into the pending pattern and leaves the slot index unchanged. In mode 1, rotor changes and the timer do not load anything.
- R5: Each hardware-triggered load takes the slot at the current index and then advances the index 0, 1, ..., 11, 0.
- R6: The rotor inputs pass through two synchronizer flops. A change in the synchronized 3-bit value counts as one position event. In mode 3, each position event loads a slot.
- R7: In mode 2, the delay timer runs freely. It produces one underflow every reload+1 cycles, and each underflow loads a slot.
- R8: In mode 4, a position event restarts the timer from the reload value. The underflow that follows, reload+1 cycles later, loads a slot. The position event itself does not load anything.
- R9: In mode 5, both a free-running timer underflow and a position event load a slot.
- R10: While `kill_in` is high, all pins are low at once, with no clock edge and no PWM edge needed.
- R11: A clock edge with `kill_in` high sets a latch that keeps all pins low. `kill_clr` clears the latch only in a cycle in which `kill_in` is low.
- R12: Write address map: addresses 0 to 11 hold the slots (data bits 5:0), address 12 holds the timer reload value (bits 15:0), and address 13 holds the mode (bits 2:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | PWM waveform to steer, synchronous to clk |
| pos_in | input | 3 | Rotor position inputs, asynchronous |
| kill_in | input | 1 | Emergency off, active high |
| kill_clr | input | 1 | Strobe that releases the kill latch |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| pat_out | output | 6 | Steered drive pins |

## Verification
The assertions assume that `pwm_in` is a clean signal, synchronous to the clock and high or low for whole cycles. They also assume that `kill_in` holds its level across at least one clock edge whenever it is raised. The bench changes every input, `pwm_in` included, only at the falling clock edge, and it holds each kill level for a full cycle. The bench triggers loads only while `pwm_in` is high or well away from a PWM falling edge, so a load never lands in the same cycle as a pattern commit. It also spaces rotor changes and timer windows far apart, so that no two load sources fire close together.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [2:0] {
    XFER_OFF     = 3'd0,
    XFER_SW      = 3'd1,
    XFER_TMR     = 3'd2,
    XFER_POS     = 3'd3,
    XFER_POS_DLY = 3'd4,
    XFER_ANY     = 3'd5
  } xfer_mode_e;
endpackage

// File: rtl/csq_pos_edge.sv
module csq_pos_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pos_async,
  output logic         pos_evt
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pos_async;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign pos_evt = |(s2_q ^ prev_q);
endmodule

// File: rtl/csq_delay_timer.sv
module csq_delay_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] reload,
  input  logic          free_run,
  input  logic          start,
  output logic          uflow
);
  logic [TW-1:0] cnt_q;
  logic          armed_q;
  logic          run;

  assign run   = free_run | armed_q;
  assign uflow = run && (cnt_q == '0) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= reload;
      armed_q <= 1'b1;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_q   <= reload;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/csq_pattern_bank.sv
module csq_pattern_bank #(
  parameter int NUM_BUF = 12,
  parameter int PAT_W   = 6,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_we,
  input  logic [IDX_W-1:0] buf_sel,
  input  logic [PAT_W-1:0] buf_wdata,
  input  logic             sw_load,
  input  logic             hw_load,
  input  logic             commit,
  output logic [PAT_W-1:0] active,
  output logic [IDX_W-1:0] idx
);
  logic [PAT_W-1:0] bank [NUM_BUF];
  logic [PAT_W-1:0] pend_q, active_q;
  logic [IDX_W-1:0] idx_q;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    logic [PAT_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (buf_we && buf_sel == IDX_W'(g))
        slot_q <= buf_wdata;
    end
    assign bank[g] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      active_q <= '0;
      idx_q    <= '0;
    end else begin
      if (sw_load) begin
        pend_q <= buf_wdata;
      end else if (hw_load) begin
        pend_q <= bank[idx_q];
        idx_q  <= (idx_q == IDX_W'(NUM_BUF - 1)) ? '0 : idx_q + 1'b1;
      end
      if (commit)
        active_q <= pend_q;
    end
  end

  assign active = active_q;
  assign idx    = idx_q;
endmodule

// File: rtl/commutation_seq.sv
module commutation_seq
  import csq_pkg::*;
#(
  parameter int NUM_BUF = 12,
  parameter int PAT_W   = 6,
  parameter int POS_W   = 3,
  parameter int TMR_W   = 16,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic [POS_W-1:0]  pos_in,
  input  logic              kill_in,
  input  logic              kill_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  output logic [PAT_W-1:0]  pat_out
);
  localparam int IDX_W       = $clog2(NUM_BUF);
  localparam int ADDR_RELOAD = NUM_BUF;
  localparam int ADDR_MODE   = NUM_BUF + 1;

  logic [2:0]       mode_q;
  logic [TMR_W-1:0] reload_q;
  logic             pwm_prev_q, pwm_fall;
  logic             kill_lat_q;
  logic             pos_evt, uflow;
  logic             free_run, tmr_start;
  logic             sw_load, hw_load, buf_we;
  logic [PAT_W-1:0] active_pat;
  logic [IDX_W-1:0] buf_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= XFER_OFF;
      reload_q   <= '0;
      pwm_prev_q <= 1'b0;
      kill_lat_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(ADDR_RELOAD)) reload_q <= wr_data;
      if (wr_en && wr_addr == ADDR_W'(ADDR_MODE))   mode_q   <= wr_data[2:0];
      pwm_prev_q <= pwm_in;
      if (kill_in)       kill_lat_q <= 1'b1;
      else if (kill_clr) kill_lat_q <= 1'b0;
    end
  end

  assign pwm_fall  = pwm_prev_q & ~pwm_in;
  assign free_run  = (mode_q == XFER_TMR) || (mode_q == XFER_ANY);
  assign tmr_start = (mode_q == XFER_POS_DLY) && pos_evt;
  assign buf_we    = wr_en && (wr_addr < ADDR_W'(NUM_BUF));
  assign sw_load   = wr_en && (wr_addr == '0) && (mode_q == XFER_SW);
  assign hw_load   = (uflow && (mode_q == XFER_TMR || mode_q == XFER_POS_DLY ||
                                mode_q == XFER_ANY))
                   || (pos_evt && (mode_q == XFER_POS || mode_q == XFER_ANY));

  csq_pos_edge #(.W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .pos_async(pos_in), .pos_evt(pos_evt)
  );

  csq_delay_timer #(.TW(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .reload(reload_q), .free_run(free_run),
    .start(tmr_start), .uflow(uflow)
  );

  csq_pattern_bank #(.NUM_BUF(NUM_BUF), .PAT_W(PAT_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_sel(IDX_W'(wr_addr)),
    .buf_wdata(wr_data[PAT_W-1:0]), .sw_load(sw_load), .hw_load(hw_load),
    .commit(pwm_fall), .active(active_pat), .idx(buf_idx)
  );

  assign pat_out = (kill_in | kill_lat_q) ? '0 : (active_pat & {PAT_W{pwm_in}});
endmodule

// File: rtl/commutation_seq_chk.sv
module commutation_seq_chk #(
  parameter int NUM_BUF = 12,
  parameter int PAT_W   = 6,
  parameter int IDX_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_in,
  input logic             kill_in,
  input logic             fall,
  input logic [2:0]       mode,
  input logic [PAT_W-1:0] active,
  input logic [IDX_W-1:0] idx,
  input logic [PAT_W-1:0] pat_out
);
  a_r2_low_when_pwm_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |-> pat_out == '0);

  a_r3_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(active));

  a_r4_sw_mode_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd1 |=> $stable(idx));

  a_r5_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IDX_W'(NUM_BUF));

  a_r10_kill_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    kill_in |-> pat_out == '0);

  a_r11_latch_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_in && $past(kill_in)) |-> pat_out == '0);
endmodule

bind commutation_seq commutation_seq_chk #(
  .NUM_BUF(NUM_BUF), .PAT_W(PAT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .kill_in(kill_in),
  .fall(pwm_fall), .mode(mode_q), .active(active_pat), .idx(buf_idx),
  .pat_out(pat_out)
);

// File: tb/commutation_seq_tb.sv
module commutation_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm_in = 1'b0;
  logic [2:0]  pos_in = '0;
  logic        kill_in = 1'b0, kill_clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  pat_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [5:0] slot_m [12];
  int idx_m = 0;
  logic [5:0] exp_q [$];
  string      req_q [$];

  always #2 clk = ~clk;

  commutation_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pos_in(pos_in),
    .kill_in(kill_in), .kill_clr(kill_clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pat_out(pat_out)
  );

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver side: push expected pin pattern
  task automatic push_exp(string req, logic [5:0] v);
    exp_q.push_back(v); req_q.push_back(req);
  endtask

  // monitor side: raise pwm, compare pins against the queue head
  task automatic sample_pins();
    @(negedge clk); pwm_in = 1'b1;
    #1;
    check(req_q.pop_front(), pat_out, exp_q.pop_front());
    @(negedge clk); pwm_in = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  // one pwm pulse to commit the pending pattern, then observe it
  task automatic show(string req, logic [5:0] v);
    @(negedge clk); pwm_in = 1'b1;
    @(negedge clk); pwm_in = 1'b0;
    @(negedge clk); @(negedge clk);
    push_exp(req, v);
    sample_pins();
  endtask

  task automatic pos_step();
    @(negedge clk); pos_in = pos_in + 3'd1;
  endtask

  function automatic logic [5:0] take_slot();
    logic [5:0] v = slot_m[idx_m];
    idx_m = (idx_m == 11) ? 0 : idx_m + 1;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, pins low even with pwm high
    @(negedge clk); pwm_in = 1'b1; #1;
    check("R1 reset pins", pat_out, 6'h00);
    @(negedge clk); pwm_in = 1'b0;

    // R12: fill slots
    for (int i = 0; i < 12; i++) begin
      slot_m[i] = 6'((i + 1) * 5);
      wr(4'(i), 16'(slot_m[i]));
    end
    show("R1 mode 0 loads nothing", 6'h00);

    // R4 / R3: software load in mode 1 while pwm is high
    wr(4'd13, 16'd1);
    @(negedge clk); pwm_in = 1'b1;
    wr(4'd0, 16'h002A);
    slot_m[0] = 6'h2A;
    #1; check("R3 no change mid pulse", pat_out, 6'h00);
    @(negedge clk); pwm_in = 1'b0;
    @(negedge clk); @(negedge clk);
    push_exp("R4 sw write of slot 0 loads", 6'h2A);
    sample_pins();
    pos_step(); repeat (6) @(negedge clk);
    show("R4 rotor ignored in mode 1", 6'h2A);

    // R6 / R5: position loads in order, with wrap
    wr(4'd13, 16'd3);
    for (int k = 0; k < 13; k++) begin
      pos_step(); repeat (4) @(negedge clk);
      show((k == 12) ? "R5 index wraps to 0" : "R6 position load", take_slot());
    end

    // R7: free-running timer, reload 200
    wr(4'd12, 16'd200);
    wr(4'd13, 16'd2);
    show("R7 first underflow load", take_slot());
    repeat (100) @(negedge clk);
    show("R7 no load before period", slot_m[(idx_m + 11) % 12]);
    repeat (110) @(negedge clk);
    show("R7 load after period", take_slot());
    wr(4'd13, 16'd0);

    // R8: delayed load, reload 30
    wr(4'd12, 16'd30);
    wr(4'd13, 16'd4);
    pos_step(); repeat (10) @(negedge clk);
    show("R8 no load during delay", slot_m[(idx_m + 11) % 12]);
    repeat (30) @(negedge clk);
    show("R8 load after delay", take_slot());

    // R9: both sources
    wr(4'd12, 16'd1000);
    wr(4'd13, 16'd5);
    repeat (40) @(negedge clk);
    show("R9 timer load", take_slot());
    pos_step(); repeat (5) @(negedge clk);
    show("R9 position load", take_slot());
    wr(4'd13, 16'd0);

    // R2: pins follow pwm and active pattern
    @(negedge clk); pwm_in = 1'b0; #1;
    check("R2 pwm low", pat_out, 6'h00);
    @(negedge clk); pwm_in = 1'b1; #1;
    check("R2 pwm high", pat_out, slot_m[(idx_m + 11) % 12]);

    // R10 / R11: kill
    @(negedge clk); kill_in = 1'b1; #1;
    check("R10 immediate off", pat_out, 6'h00);
    @(negedge clk); kill_in = 1'b0; #1;
    check("R11 latched off", pat_out, 6'h00);
    @(negedge clk); kill_in = 1'b1; kill_clr = 1'b1;
    @(negedge clk); kill_in = 1'b0; kill_clr = 1'b0; #1;
    check("R11 clear ignored while active", pat_out, 6'h00);
    @(negedge clk); kill_clr = 1'b1;
    @(negedge clk); kill_clr = 1'b0; #1;
    check("R11 cleared", pat_out, slot_m[(idx_m + 11) % 12]);
    @(negedge clk); pwm_in = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule